// File: doc/BRIEF.md
# Free-Running Compare Timer

A 16-bit up-counter runs without pause while its run enable is high. It wraps from FFFFH to 0000H and is never cleared by a compare hit. Two compare channels watch the shared count. When the count equals a channel's stored value, that channel gives a one-clock interrupt pulse and flips its toggle output.

A host loads compare values through a one-cycle write strobe. To get a steady stream of intervals, software loads `D-1` for the first interval of length `D`. On each interrupt it adds the next interval to the value it loaded before and keeps only the low 16 bits. Each channel can follow its own interval sequence, and both channels share the one counter.

Top module: `fr_cmp_timer`

## Requirements
- R1: While `rst_n` is low, `cnt_o` is 0000H, `irq_o` is 00 and `tgl_o` is 00. Both compare registers reset to 0000H.
- R2: While `run_en` is high, `cnt_o` rises by one on every clock edge. The step after FFFFH is 0000H.
- R3: With `run_en` low, `cnt_o` becomes 0000H at the next edge and stays there. When `run_en` returns high, the count restarts from 0000H, so the value 0000H is compared first.
- R4: Suppose `run_en` is high and `cnt_o` equals compare value N before an edge. Then `irq_o[N]` is high for exactly the following cycle. The counter still steps normally and is not cleared by the match.
- R5: `tgl_o[N]` inverts at the same edge that raises `irq_o[N]`. It changes at no other time.
- R6: With `wr_en` high at an edge, `wr_data` is stored in the compare register picked by `wr_sel` (0 selects channel 0, 1 selects channel 1). Matching uses the new value from that edge onward, so a value one above the current count produces a pulse two cycles after the write is driven.
- R7: Load compare value `D-1`, then raise `run_en`. The first pulse appears D clocks later. After that, each pulse comes `(new - old) mod 65536` clocks after the previous one, even when the new value wrapped past FFFFH.
- R8: While `run_en` is low, no interrupt pulse appears and no toggle output changes, whatever the compare values hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Count enable; low holds the counter at zero |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | Channel selected for the write |
| wr_data | input | 16 | Compare value to store |
| cnt_o | output | 16 | Current counter value |
| irq_o | output | 2 | One-cycle match pulse per channel |
| tgl_o | output | 2 | Toggle output per channel |

## Verification
The assertions check the following on every cycle:
- the counter steps by one or holds at zero, depending on the enable;
- each interrupt lasts one cycle;
- a toggle moves only together with its interrupt;
- nothing fires while the timer is stopped.

Some behaviour only the bench scenarios can show. These are the exact arrival times of the pulses relative to the compare values, and the interval that follows when a software-advanced compare value wraps past FFFFH. They also include the immediate effect of a write and the restart from zero after the enable is cleared.

// File: rtl/fr_cmp_timer.sv
module fr_cmp_timer #(
  parameter int W   = 16,
  parameter int NCH = 2,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   cnt_o,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] tgl_o
);

  logic [W-1:0]   cnt_q;
  logic [W-1:0]   cmp_q [NCH];
  logic [NCH-1:0] hit;
  logic [NCH-1:0] irq_q, tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_en) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit[g] = run_en && (cnt_q == cmp_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cmp_q[g] <= '0;
      else if (wr_en && wr_sel == SW'(g))      cmp_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      tgl_q <= '0;
    end else begin
      irq_q <= hit;
      tgl_q <= tgl_q ^ hit;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
  assign tgl_o = tgl_q;

endmodule

// File: rtl/fr_cmp_timer_chk.sv
module fr_cmp_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_en,
  input logic [W-1:0]   cnt_o,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] tgl_o
);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> cnt_o == W'($past(cnt_o) + 1'b1));

  // R3
  cnt_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> cnt_o == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |=> !irq_o[g]);

    // R5
    tgl_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl_o[g] != $past(tgl_o[g])) |-> irq_o[g]);

    // R5
    irq_flips_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> (tgl_o[g] != $past(tgl_o[g])));

    // R8
    no_irq_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> $past(run_en));
  end

endmodule

bind fr_cmp_timer fr_cmp_timer_chk #(.W(W), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en),
  .cnt_o(cnt_o), .irq_o(irq_o), .tgl_o(tgl_o)
);

// File: tb/fr_cmp_timer_tb_top.sv
module fr_cmp_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic [1:0]  irq_o, tgl_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // {ch0 first, ch0 next, ch1 first, ch1 next}; later intervals >= 4
  localparam int NV = 3;
  localparam int VEC [NV][4] = '{
    '{5,     7,  8,   4},
    '{1,     10, 20,  6},
    '{65530, 20, 100, 65500}
  };

  fr_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cnt_o(cnt_o),
    .irq_o(irq_o), .tgl_o(tgl_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycles %0d expected < 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int val);
    wr_en = 1'b1; wr_sel = 1'(ch); wr_data = 16'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_vec(input int d0a, input int d0b, input int d1a, input int d1b);
    int da[2], db[2], t1[2], t2[2], n[2], nv[2];
    bit pend[2];
    int k, lim, cnt_err, tgl_err;
    logic [1:0] tgl0;
    da = '{d0a, d1a}; db = '{d0b, d1b};
    run_en = 1'b0;
    @(negedge clk);
    wr(0, d0a - 1);
    wr(1, d1a - 1);
    tgl0 = tgl_o;
    for (int c = 0; c < 2; c++) begin
      t1[c] = -1; t2[c] = -1; n[c] = 0; pend[c] = 0; nv[c] = 0;
    end
    lim = (d0a + d0b > d1a + d1b ? d0a + d0b : d1a + d1b) + 3;
    cnt_err = 0; tgl_err = 0;
    run_en = 1'b1;
    for (k = 1; k <= lim; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (cnt_o != 16'(k)) cnt_err++;
      for (int c = 0; c < 2; c++) begin
        if (irq_o[c]) begin
          n[c]++;
          if (n[c] == 1) begin
            t1[c] = k; pend[c] = 1; nv[c] = (da[c] - 1 + db[c]) & 16'hFFFF;
          end else if (n[c] == 2) t2[c] = k;
          if (tgl_o[c] != (tgl0[c] ^ n[c][0])) tgl_err++;
        end
      end
      if (pend[0]) begin
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'(nv[0]); pend[0] = 0;
      end else if (pend[1]) begin
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'(nv[1]); pend[1] = 0;
      end
    end
    run_en = 1'b0;
    // R2: count follows clocks and wraps
    chk(cnt_err == 0, "R2 counter sequence", cnt_err, 0);
    for (int c = 0; c < 2; c++) begin
      // R7 first interval D, then difference mod 2^16
      chk(t1[c] == da[c], $sformatf("R7 ch%0d first pulse", c), t1[c], da[c]);
      chk(t2[c] == da[c] + db[c], $sformatf("R7 ch%0d second pulse", c), t2[c], da[c] + db[c]);
      // R4: exactly one pulse per match
      chk(n[c] == 2, $sformatf("R4 ch%0d pulse count", c), n[c], 2);
      // R5
      chk(tgl_err == 0 && tgl_o[c] == tgl0[c], $sformatf("R5 ch%0d toggle", c), tgl_o[c], tgl0[c]);
    end
  endtask

  initial begin
    int c;
    logic [1:0] snap;
    @(negedge clk);
    // R1
    chk(cnt_o == 0, "R1 cnt reset", cnt_o, 0);
    chk(irq_o == 0, "R1 irq reset", irq_o, 0);
    chk(tgl_o == 0, "R1 tgl reset", tgl_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R6: write takes effect immediately
    wr(0, 16'h8000);
    wr(1, 16'h8000);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    c = cnt_o;
    wr(0, c + 1);
    chk(irq_o[0] == 1'b0, "R6 no pulse before match", irq_o[0], 0);
    @(negedge clk);
    chk(irq_o[0] == 1'b1, "R6 pulse after written value", irq_o[0], 1);
    // R4: counter not cleared by a match
    chk(cnt_o == 16'(c + 2), "R4 counter continues", cnt_o, c + 2);

    // R3: disable clears
    run_en = 1'b0;
    @(negedge clk);
    chk(cnt_o == 0, "R3 disable clears count", cnt_o, 0);
    wr(0, 0);
    wr(1, 0);
    snap = tgl_o;
    repeat (4) @(negedge clk);
    // R8
    chk(irq_o == 0, "R8 no pulse while stopped", irq_o, 0);
    chk(tgl_o == snap, "R8 toggle frozen while stopped", tgl_o, snap);
    chk(cnt_o == 0, "R3 count held at zero", cnt_o, 0);
    run_en = 1'b1;
    @(negedge clk);
    chk(cnt_o == 1, "R3 restart from zero", cnt_o, 1);
    chk(irq_o == 2'b11, "R3 zero compared first", irq_o, 3);
    @(negedge clk);
    chk(irq_o == 2'b00, "R4 single-cycle pulse", irq_o, 0);
    run_en = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule